// File: doc/BRIEF.md
# Marker-Driven Instruction Start Finder

This block sits between an instruction line store and a group of decoders. Each line holds sixteen bytes of variable-length code. When a line is filled, a small predecode stage walks the line from its first byte. It uses a per-byte length hint and records a single end bit on the final byte of every instruction that finishes inside the line. Writing these end bits adds one cycle to the fill before the line is declared usable.

When a fetch request arrives with a byte offset at which control enters the line, the block uses the stored end bits to cut out instructions without looking at opcodes. The first instruction begins at the entry offset. Each further one begins on the byte after a set end bit. Up to three (start, length) pairs are presented per cycle in ascending byte order. An instruction that starts inside the line but has no end bit in it is flagged as incomplete and is not presented. If the entry offset does not sit on a boundary that the end bits agree with, for example a jump into the middle of a previously predecoded instruction, the block raises a mismatch so the line can be predecoded again. In that case it presents nothing.

Top module: `predecode_splitter`

## Requirements
- R1: While reset is held and afterwards until the first fill completes, `line_ready_o` is 0. `slot_valid_o`, `slot_start_o`, `slot_len_o`, `incomplete_o` and `mismatch_o` are all 0.
- R2: A fill accepted at a clock edge drives `line_ready_o` to 0 after that edge. `line_ready_o` returns to 1 after the following edge, once the end bits are written.
- R3: The fill hint for byte b sits in `fill_hint_i[4b+3:4b]` and holds the instruction length minus one (1 to 16 bytes). Predecode starts at byte 0 and jumps from each instruction to the byte after its end. It marks the end byte only when that byte lies inside the line.
- R4: For a request that is accepted and not mismatched, slot 0 (when valid) starts at the requested entry offset.
- R5: Slot s+1 starts on the byte after slot s ends. Starts rise strictly. Valid slots are contiguous from slot 0 (`slot_valid_o` bit s is slot s). At most 3 slots are emitted.
- R6: A valid slot's length equals its end byte minus its start byte plus one. Slot s uses `slot_start_o[4s+3:4s]` and `slot_len_o[5s+4:5s]`. Invalid slots read 0 in both fields.
- R7: `incomplete_o` is 1 exactly when fewer than 3 slots are emitted and the next instruction start still lies inside the line with no end bit at or after it.
- R8: With a nonzero entry offset e, `mismatch_o` is 1 when the end bit of byte e-1 is clear. A mismatch forces all slots invalid and `incomplete_o` to 0. Entry offset 0 is always a boundary.
- R9: Outputs are registered. A request sampled at an edge is reflected after that edge. A cycle with no request, or with `line_ready_o` low at the sampling edge, yields all outputs 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid_i | input | 1 | New line arrives for predecode |
| fill_hint_i | input | 64 | Per-byte length-minus-one hints, 4 bits per byte |
| req_valid_i | input | 1 | Fetch request into the stored line |
| req_entry_i | input | 4 | Byte offset where control enters the line |
| line_ready_o | output | 1 | End bits for the stored line are valid |
| slot_valid_o | output | 3 | Per-slot valid, contiguous from slot 0 |
| slot_start_o | output | 12 | Per-slot start offset, 4 bits per slot |
| slot_len_o | output | 15 | Per-slot length in bytes, 5 bits per slot |
| incomplete_o | output | 1 | An instruction starts in the line but ends beyond it |
| mismatch_o | output | 1 | Entry offset disagrees with the stored end bits |

## Verification
The bench builds the block with its defaults: a 16-byte line, three output slots and 4-bit hints. At that size a single 16-byte instruction spanning the whole line can be reached, as can entry at the very last byte, a group that fills all three slots, and an instruction running off the line end. Uniform 4-byte code, mixed 1/2/5-byte code with an overrunning tail, one full-line instruction and all single-byte code are each entered at aligned and misaligned offsets. The bench also probes requests made while the fill stage is still writing end bits.

// File: rtl/psplit_pkg.sv
// Shared defaults for the instruction start finder.
// Assumes: line sizes are powers of two, hint width equals offset width.
package psplit_pkg;
    localparam int DEF_LINE_BYTES = 16;
    localparam int DEF_SLOTS      = 3;
endpackage

// File: rtl/psplit_predecode.sv
// Fill-side predecode: registers the incoming hints, then walks the line from
// byte 0 one cycle later and stores an end bit on every instruction's last
// byte that falls inside the line. Declares the line ready once written.
// Assumes: hint value h means an instruction of h+1 bytes.
module psplit_predecode #(
    parameter int LINE_BYTES = 16,
    parameter int OFF_W      = $clog2(LINE_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_valid_i,
    input  logic [LINE_BYTES*OFF_W-1:0] fill_hint_i,
    output logic [LINE_BYTES-1:0]       end_bits_o,
    output logic                        ready_o
);
    logic [LINE_BYTES*OFF_W-1:0] hint_q;
    logic                        pend_q;
    logic [LINE_BYTES-1:0]       end_q;
    logic                        ready_q;
    logic [LINE_BYTES-1:0]       end_c;

    // Walk the registered hints from byte 0 and place end bits.
    always_comb begin
        int pos;
        int nxt;
        end_c = '0;
        pos   = 0;
        nxt   = 0;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (b == pos) begin
                nxt = b + int'(hint_q[b*OFF_W +: OFF_W]) + 1;
                for (int e = 0; e < LINE_BYTES; e++) begin
                    if (e + 1 == nxt) end_c[e] = 1'b1;
                end
                pos = nxt;
            end
        end
    end

    // Two-step fill: capture hints, then commit end bits and raise ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hint_q  <= '0;
            pend_q  <= 1'b0;
            end_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            pend_q <= fill_valid_i;
            if (fill_valid_i) begin
                hint_q  <= fill_hint_i;
                ready_q <= 1'b0;
            end else if (pend_q) begin
                end_q   <= end_c;
                ready_q <= 1'b1;
            end
        end
    end

    assign end_bits_o = end_q;
    assign ready_o    = ready_q;
endmodule

// File: rtl/psplit_slots.sv
// Combinational slot cutter: from an entry offset and the stored end bits,
// chains up to SLOTS instructions in ascending order, flags an unterminated
// instruction and an entry that the end bits do not treat as a boundary.
// Assumes: byte 0 of a line is always a boundary.
module psplit_slots #(
    parameter int LINE_BYTES = 16,
    parameter int SLOTS      = 3,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = OFF_W + 1
) (
    input  logic                   en_i,
    input  logic [LINE_BYTES-1:0]  end_bits_i,
    input  logic [OFF_W-1:0]       entry_i,
    output logic [SLOTS-1:0]       vld_o,
    output logic [SLOTS*OFF_W-1:0] start_o,
    output logic [SLOTS*LEN_W-1:0] len_o,
    output logic                   incomplete_o,
    output logic                   mismatch_o
);
    localparam logic [LEN_W-1:0] LINE_END = LEN_W'(LINE_BYTES);

    logic [LEN_W-1:0] cur  [SLOTS+1];
    logic             live [SLOTS+1];
    logic [SLOTS-1:0] inc_v;
    logic [OFF_W-1:0] prev_byte;

    assign prev_byte  = entry_i - 1'b1;
    assign mismatch_o = en_i && (entry_i != '0) && !end_bits_i[prev_byte];
    assign cur[0]     = {1'b0, entry_i};
    assign live[0]    = en_i && !mismatch_o;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic             hit;
        logic [LEN_W-1:0] endp;
        logic             in_line;
        logic             v;

        // Lowest set end bit at or above this slot's start.
        always_comb begin
            hit  = 1'b0;
            endp = '0;
            for (int e = LINE_BYTES - 1; e >= 0; e--) begin
                if (end_bits_i[e] && (LEN_W'(e) >= cur[s])) begin
                    hit  = 1'b1;
                    endp = LEN_W'(e);
                end
            end
        end

        assign in_line  = cur[s] < LINE_END;
        assign v        = live[s] && in_line && hit;
        assign inc_v[s] = live[s] && in_line && !hit;
        assign vld_o[s] = v;
        assign start_o[s*OFF_W +: OFF_W] = v ? cur[s][OFF_W-1:0] : '0;
        assign len_o[s*LEN_W +: LEN_W]   = v ? (endp - cur[s] + 1'b1) : '0;
        assign cur[s+1]  = endp + 1'b1;
        assign live[s+1] = v;
    end

    assign incomplete_o = |inc_v;
endmodule

// File: rtl/predecode_splitter.sv
// Top: predecode fill stage plus slot cutter, with registered outputs.
// Assumes: a request is served from the line held at its sampling edge.
module predecode_splitter #(
    parameter int LINE_BYTES = psplit_pkg::DEF_LINE_BYTES,
    parameter int SLOTS      = psplit_pkg::DEF_SLOTS,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = OFF_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_valid_i,
    input  logic [LINE_BYTES*OFF_W-1:0] fill_hint_i,
    input  logic                        req_valid_i,
    input  logic [OFF_W-1:0]            req_entry_i,
    output logic                        line_ready_o,
    output logic [SLOTS-1:0]            slot_valid_o,
    output logic [SLOTS*OFF_W-1:0]      slot_start_o,
    output logic [SLOTS*LEN_W-1:0]      slot_len_o,
    output logic                        incomplete_o,
    output logic                        mismatch_o
);
    logic [LINE_BYTES-1:0]  end_bits;
    logic                   ready;
    logic [SLOTS-1:0]       vld_c;
    logic [SLOTS*OFF_W-1:0] start_c;
    logic [SLOTS*LEN_W-1:0] len_c;
    logic                   inc_c;
    logic                   mm_c;

    psplit_predecode #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_pre (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid_i (fill_valid_i),
        .fill_hint_i  (fill_hint_i),
        .end_bits_o   (end_bits),
        .ready_o      (ready)
    );

    psplit_slots #(.LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS),
                   .OFF_W(OFF_W), .LEN_W(LEN_W)) u_cut (
        .en_i         (req_valid_i && ready),
        .end_bits_i   (end_bits),
        .entry_i      (req_entry_i),
        .vld_o        (vld_c),
        .start_o      (start_c),
        .len_o        (len_c),
        .incomplete_o (inc_c),
        .mismatch_o   (mm_c)
    );

    // Register the cut result for the decoders.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid_o <= '0;
            slot_start_o <= '0;
            slot_len_o   <= '0;
            incomplete_o <= 1'b0;
            mismatch_o   <= 1'b0;
        end else begin
            slot_valid_o <= vld_c;
            slot_start_o <= start_c;
            slot_len_o   <= len_c;
            incomplete_o <= inc_c;
            mismatch_o   <= mm_c;
        end
    end

    assign line_ready_o = ready;
endmodule

// File: rtl/psplit_chk.sv
// Property checker for the start finder, attached by bind.
module psplit_chk #(
    parameter int LINE_BYTES = 16,
    parameter int SLOTS      = 3,
    parameter int OFF_W      = 4,
    parameter int LEN_W      = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        fill_valid_i,
    input logic [LINE_BYTES*OFF_W-1:0] fill_hint_i,
    input logic                        req_valid_i,
    input logic [OFF_W-1:0]            req_entry_i,
    input logic                        line_ready_o,
    input logic [SLOTS-1:0]            slot_valid_o,
    input logic [SLOTS*OFF_W-1:0]      slot_start_o,
    input logic [SLOTS*LEN_W-1:0]      slot_len_o,
    input logic                        incomplete_o,
    input logic                        mismatch_o
);
    // R2
    fill_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_valid_i) |-> !line_ready_o);
    // R5
    slots_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid_o + 1'b1) & slot_valid_o) == '0);
    // R4
    first_start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o[0] |-> slot_start_o[OFF_W-1:0] == $past(req_entry_i));
    // R6
    first_len_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o[0] |-> (slot_len_o[LEN_W-1:0] != '0) &&
        ({1'b0, slot_start_o[OFF_W-1:0]} + slot_len_o[LEN_W-1:0] <= LEN_W'(LINE_BYTES)));
    // R8
    mismatch_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> (slot_valid_o == '0) && !incomplete_o);
    // R9
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid_i && line_ready_o) |-> (slot_valid_o == '0) && !mismatch_o && !incomplete_o);
endmodule

bind predecode_splitter psplit_chk #(
    .LINE_BYTES(LINE_BYTES), .SLOTS(SLOTS), .OFF_W(OFF_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/predecode_splitter_bench.sv
module predecode_splitter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic [63:0] hint;
        logic [3:0]  entry;
        logic [2:0]  vld;
        logic [11:0] st;
        logic [14:0] ln;
        logic        inc;
        logic        mm;
    } vec_t;

    localparam logic [63:0] HA = 64'h3333333333333333;
    localparam logic [63:0] HB = 64'hFFFFFFF9FFFF4F10;
    localparam logic [63:0] HC = 64'h000000000000000F;
    localparam logic [63:0] HD = 64'h0;

    localparam vec_t VECS [NVEC] = '{
        '{HA, 4'd0,  3'b111, {4'd8, 4'd4, 4'd0},   {5'd4, 5'd4, 5'd4},  1'b0, 1'b0},
        '{HA, 4'd8,  3'b011, {4'd0, 4'd12, 4'd8},  {5'd0, 5'd4, 5'd4},  1'b0, 1'b0},
        '{HA, 4'd5,  3'b000, 12'h0,                15'h0,               1'b0, 1'b1},
        '{HA, 4'd4,  3'b111, {4'd12, 4'd8, 4'd4},  {5'd4, 5'd4, 5'd4},  1'b0, 1'b0},
        '{HB, 4'd0,  3'b111, {4'd3, 4'd1, 4'd0},   {5'd5, 5'd2, 5'd1},  1'b0, 1'b0},
        '{HB, 4'd3,  3'b001, {4'd0, 4'd0, 4'd3},   {5'd0, 5'd0, 5'd5},  1'b1, 1'b0},
        '{HB, 4'd8,  3'b000, 12'h0,                15'h0,               1'b1, 1'b0},
        '{HB, 4'd1,  3'b011, {4'd0, 4'd3, 4'd1},   {5'd0, 5'd5, 5'd2},  1'b1, 1'b0},
        '{HC, 4'd0,  3'b001, {4'd0, 4'd0, 4'd0},   {5'd0, 5'd0, 5'd16}, 1'b0, 1'b0},
        '{HC, 4'd15, 3'b000, 12'h0,                15'h0,               1'b0, 1'b1},
        '{HD, 4'd15, 3'b001, {4'd0, 4'd0, 4'd15},  {5'd0, 5'd0, 5'd1},  1'b0, 1'b0},
        '{HD, 4'd13, 3'b111, {4'd15, 4'd14, 4'd13},{5'd1, 5'd1, 5'd1},  1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_valid_i;
    logic [63:0] fill_hint_i;
    logic        req_valid_i;
    logic [3:0]  req_entry_i;
    logic        line_ready_o;
    logic [2:0]  slot_valid_o;
    logic [11:0] slot_start_o;
    logic [14:0] slot_len_o;
    logic        incomplete_o;
    logic        mismatch_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    predecode_splitter u_predecode_splitter (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid_i (fill_valid_i),
        .fill_hint_i  (fill_hint_i),
        .req_valid_i  (req_valid_i),
        .req_entry_i  (req_entry_i),
        .line_ready_o (line_ready_o),
        .slot_valid_o (slot_valid_o),
        .slot_start_o (slot_start_o),
        .slot_len_o   (slot_len_o),
        .incomplete_o (incomplete_o),
        .mismatch_o   (mismatch_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input logic [63:0] h);
        @(negedge clk);
        fill_valid_i = 1'b1;
        fill_hint_i  = h;
        @(negedge clk);
        fill_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_req(input logic [3:0] e);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_entry_i = e;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        fill_valid_i = 1'b0;
        fill_hint_i  = '0;
        req_valid_i  = 1'b0;
        req_entry_i  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'b0, line_ready_o}, 32'd0);
        chk("R1 outputs", {slot_valid_o, slot_start_o, incomplete_o, mismatch_o}, 32'd0);
        rst_n = 1'b1;
        // R9: request before any fill yields nothing
        do_req(4'd0);
        chk("R1 R9 no line", {27'b0, slot_valid_o, incomplete_o, mismatch_o}, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            do_fill(VECS[i].hint);
            chk("R2 ready after fill", {31'b0, line_ready_o}, 32'd1);
            do_req(VECS[i].entry);
            chk($sformatf("R3 R4 R5 valid v%0d", i), {29'b0, slot_valid_o}, {29'b0, VECS[i].vld});
            chk($sformatf("R4 R5 starts v%0d", i), {20'b0, slot_start_o}, {20'b0, VECS[i].st});
            chk($sformatf("R6 lengths v%0d", i), {17'b0, slot_len_o}, {17'b0, VECS[i].ln});
            chk($sformatf("R7 incomplete v%0d", i), {31'b0, incomplete_o}, {31'b0, VECS[i].inc});
            chk($sformatf("R8 mismatch v%0d", i), {31'b0, mismatch_o}, {31'b0, VECS[i].mm});
        end

        // R9: cycle without request clears outputs
        @(negedge clk);
        chk("R9 idle", {27'b0, slot_valid_o, incomplete_o, mismatch_o}, 32'd0);

        // R2: ready drops right after fill edge; request then is ignored (R9)
        @(negedge clk);
        fill_valid_i = 1'b1;
        fill_hint_i  = HA;
        @(negedge clk);
        fill_valid_i = 1'b0;
        chk("R2 ready low", {31'b0, line_ready_o}, 32'd0);
        req_valid_i = 1'b1;
        req_entry_i = 4'd0;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R9 busy line", {27'b0, slot_valid_o, incomplete_o, mismatch_o}, 32'd0);
        chk("R2 ready back", {31'b0, line_ready_o}, 32'd1);
        do_req(4'd12);
        chk("R5 R6 tail slot", {17'b0, slot_start_o[3:0], slot_len_o[4:0], 3'b0, slot_valid_o},
            {17'b0, 4'd12, 5'd4, 3'b0, 3'b001});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule